// File: doc/BRIEF.md
# Flow-Through Zero-Turnaround Burst SRAM

This block is a small-depth synchronous SRAM with a flow-through read path and pipelined writes. Read and write commands can be mixed freely on consecutive clock cycles, and no idle cycle is needed when the bus changes direction. Each enabled cycle moves one data word. Commands are captured on the rising edge. Read data for a command appears combinationally in the following cycle. Write data and its lane mask are taken at the next enabled edge after the write command.

A load cycle starts an access at a full address. Advance cycles then step the two low address bits through a four-beat burst, in linear or interleaved order. A clock enable freezes the whole pipeline. An asynchronous output enable gates only the output drivers. The drivers are also turned off internally whenever the current cycle is a write data phase.

Top module: `zt_flow_sram`

## Requirements
- R1: While reset is asserted and after it is released, `drive_en` is 0 and `rdata` is 0 until a read command is loaded.
- R2: A selected load with `wr_n`=1 at an enabled edge makes `rdata` equal to the stored word at that address in the following cycle, with no further edge, and sets `drive_en` to the inverse of `out_en_n`.
- R3: A selected load with `wr_n`=0 takes `wdata` and `lane_we` at the next enabled edge. Lane g is bits [9g+8:9g] and is written only when `lane_we[g]`=1 (active high). Other lanes keep their old contents.
- R4: A read loaded at the edge that completes a write, to the same address, returns the newly written data. Writes and reads may alternate on every cycle.
- R5: The device is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0 at a load edge. Any other combination is a deselect: the next cycle has `drive_en`=0, and nothing is written.
- R6: During the data phase of a write, `drive_en` is 0 whatever the value of `out_en_n`.
- R7: `out_en_n` acts without a clock edge. When it is 1, `drive_en` is 0. When it is 0, `drive_en` follows the current read state. It never changes stored data or command state.
- R8: An edge with `clk_en`=0 is ignored. Command state, burst position and memory hold, `rdata` is unchanged, and write data is taken only at the next enabled edge.
- R9: With `burst_ilv`=0, the n-th advance after a load with start bits s addresses low bits (s+n) mod 4. The upper address bits are unchanged.
- R10: With `burst_ilv`=1, the n-th advance addresses low bits s XOR n.
- R11: An advance cycle (`adv_ld`=1) ignores the chip enables and continues the previous operation type. After a deselect, an advance stays deselected, with `drive_en`=0 and no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Edge qualifier; 0 freezes all state |
| cs1_n | input | 1 | Chip enable, active low |
| cs2 | input | 1 | Chip enable, active high |
| cs3_n | input | 1 | Chip enable, active low |
| wr_n | input | 1 | 0 = write, 1 = read, sampled at a load |
| adv_ld | input | 1 | 0 = load new address, 1 = advance burst |
| burst_ilv | input | 1 | 0 = linear burst, 1 = interleaved burst |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W | Word address for a load |
| lane_we | input | LANES | Per-lane write enables, data phase |
| wdata | input | LANES*LANE_W | Write data, data phase |
| rdata | output | LANES*LANE_W | Read data, flow-through |
| drive_en | output | 1 | Output driver enable for the data bus |

## Verification
The bench targets the same-address read right after a write. A design that committed writes one cycle late would return stale data there. It sweeps all sixteen lane masks, which catches swapped or inverted lane selects. It tries all eight chip-enable combinations, and a wrong polarity would let a deselected write land. It steps both burst orders from every start offset, where a confused order or a carry into the upper bits reads the wrong word. Frozen cycles carry junk write data and a conflicting command. A pipeline that leaked through a disabled edge would write the junk or move its output. Write data phases run with the output enable active, which catches drivers left on during a write.

// File: rtl/zt_pkg.sv
package zt_pkg;

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_RD   = 2'd1,
        OP_WR   = 2'd2
    } op_e;

    localparam int BURST_W = 2;

    // next burst offset from start bits and beat count
    function automatic logic [BURST_W-1:0] burst_ofs(
        input logic [BURST_W-1:0] start,
        input logic [BURST_W-1:0] cnt,
        input logic               ilv
    );
        return ilv ? (start ^ cnt) : (start + cnt);
    endfunction

endpackage

// File: rtl/zt_ctrl.sv
module zt_ctrl
    import zt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              sel,
    input  logic              wr_n,
    input  logic              adv_ld,
    input  logic              burst_ilv,
    input  logic [ADDR_W-1:0] addr,
    output op_e               op,
    output logic [ADDR_W-1:0] cur_addr
);

    typedef struct packed {
        op_e                op;
        logic [ADDR_W-1:0]  base;
        logic [BURST_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clk_en) begin
            if (!adv_ld) begin
                if (sel) begin
                    st_d.op   = wr_n ? OP_RD : OP_WR;
                    st_d.base = addr;
                    st_d.cnt  = '0;
                end else begin
                    st_d.op = OP_IDLE;
                end
            end else if (st_q.op != OP_IDLE) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign op       = st_q.op;
    assign cur_addr = {st_q.base[ADDR_W-1:BURST_W],
                       burst_ofs(st_q.base[BURST_W-1:0], st_q.cnt, burst_ilv)};

endmodule

// File: rtl/zt_lane.sv
module zt_lane #(
    parameter int ADDR_W = 6,
    parameter int LANE_W = 9
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[addr] <= din;
        end
    end

    assign dout = mem_q[addr];

endmodule

// File: rtl/zt_out.sv
module zt_out
    import zt_pkg::*;
#(
    parameter int DATA_W = 36
) (
    input  op_e               op,
    input  logic              out_en_n,
    input  logic [DATA_W-1:0] rd_word,
    output logic              drive_en,
    output logic [DATA_W-1:0] rdata
);

    always_comb begin
        drive_en = (op == OP_RD) && !out_en_n;
        rdata    = (op == OP_RD) ? rd_word : '0;
    end

endmodule

// File: rtl/zt_flow_sram.sv
module zt_flow_sram
    import zt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clk_en,
    input  logic                     cs1_n,
    input  logic                     cs2,
    input  logic                     cs3_n,
    input  logic                     wr_n,
    input  logic                     adv_ld,
    input  logic                     burst_ilv,
    input  logic                     out_en_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [LANES-1:0]         lane_we,
    input  logic [LANES*LANE_W-1:0]  wdata,
    output logic [LANES*LANE_W-1:0]  rdata,
    output logic                     drive_en
);

    localparam int DATA_W = LANES * LANE_W;

    op_e               op;
    logic [ADDR_W-1:0] cur_addr;
    logic [DATA_W-1:0] rd_word;
    logic              sel;
    logic              wr_fire;

    assign sel     = !cs1_n && cs2 && !cs3_n;
    assign wr_fire = clk_en && (op == OP_WR);

    zt_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .clk_en    (clk_en),
        .sel       (sel),
        .wr_n      (wr_n),
        .adv_ld    (adv_ld),
        .burst_ilv (burst_ilv),
        .addr      (addr),
        .op        (op),
        .cur_addr  (cur_addr)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        zt_lane #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lane (
            .clk   (clk),
            .wr_en (wr_fire && lane_we[g]),
            .addr  (cur_addr),
            .din   (wdata[g*LANE_W +: LANE_W]),
            .dout  (rd_word[g*LANE_W +: LANE_W])
        );
    end

    zt_out #(.DATA_W(DATA_W)) u_out (
        .op       (op),
        .out_en_n (out_en_n),
        .rd_word  (rd_word),
        .drive_en (drive_en),
        .rdata    (rdata)
    );

endmodule

// File: rtl/zt_chk.sv
module zt_chk #(
    parameter int DATA_W = 36
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clk_en,
    input logic              cs1_n,
    input logic              cs2,
    input logic              cs3_n,
    input logic              wr_n,
    input logic              adv_ld,
    input logic              out_en_n,
    input logic              drive_en,
    input logic [DATA_W-1:0] rdata
);

    logic sel;
    assign sel = !cs1_n && cs2 && !cs3_n;

    // R2
    rd_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && sel && wr_n) |=> (drive_en == !out_en_n));

    // R6
    wr_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && sel && !wr_n) |=> !drive_en);

    // R5
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && !sel) |=> !drive_en);

    // R7
    oe_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> !drive_en);

    // R8
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(rdata));

    // R11
    adv_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && !drive_en && !out_en_n) |=> !drive_en);

endmodule

bind zt_flow_sram zt_chk #(.DATA_W(LANES*LANE_W)) u_zt_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .cs1_n    (cs1_n),
    .cs2      (cs2),
    .cs3_n    (cs3_n),
    .wr_n     (wr_n),
    .adv_ld   (adv_ld),
    .out_en_n (out_en_n),
    .drive_en (drive_en),
    .rdata    (rdata)
);

// File: tb/test_zt_flow_sram.sv
module test_zt_flow_sram;

    localparam int CLK_PERIOD = 10;
    localparam int AW    = 6;
    localparam int LN    = 4;
    localparam int LW    = 9;
    localparam int DW    = LN * LW;
    localparam int DEPTH = 1 << AW;
    localparam logic [2:0] SEL = 3'b010;
    localparam logic [2:0] DSL = 3'b110;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clk_en = 1'b1;
    logic          cs1_n = 1'b1, cs2 = 1'b0, cs3_n = 1'b1;
    logic          wr_n = 1'b1, adv_ld = 1'b0, burst_ilv = 1'b0, out_en_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [LN-1:0] lane_we = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          drive_en;

    int n_tests = 0;
    int n_fail  = 0;

    logic [DW-1:0] m_mem [DEPTH];
    int            m_op = 0;   // 0 idle, 1 read, 2 write
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_cnt = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zt_flow_sram #(.ADDR_W(AW), .LANES(LN), .LANE_W(LW)) i_zt_flow_sram (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .cs1_n(cs1_n), .cs2(cs2),
        .cs3_n(cs3_n), .wr_n(wr_n), .adv_ld(adv_ld), .burst_ilv(burst_ilv),
        .out_en_n(out_en_n), .addr(addr), .lane_we(lane_we), .wdata(wdata),
        .rdata(rdata), .drive_en(drive_en)
    );

    function automatic logic [AW-1:0] m_addr();
        logic [1:0] lo;
        lo = burst_ilv ? (m_base[1:0] ^ m_cnt) : (m_base[1:0] + m_cnt);
        return {m_base[AW-1:2], lo};
    endfunction

    function automatic logic [DW-1:0] pat(input int a, input int s);
        logic [DW-1:0] r;
        for (int g = 0; g < LN; g++) r[g*LW +: LW] = LW'(a*7 + g*61 + s*13 + 3);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_out(input string tag);
        chk(tag, DW'(drive_en), DW'((m_op == 1) && !out_en_n));
        chk(tag, rdata, (m_op == 1) ? m_mem[m_addr()] : '0);
    endtask

    task automatic cyc(input string tag, input logic ce, input logic [2:0] cs,
                       input logic wn, input logic adv, input logic [AW-1:0] a,
                       input logic [DW-1:0] wd, input logic [LN-1:0] lw);
        clk_en = ce; {cs1_n, cs2, cs3_n} = cs; wr_n = wn; adv_ld = adv;
        addr = a; wdata = wd; lane_we = lw;
        @(posedge clk);
        if (ce) begin
            if (m_op == 2) begin
                logic [AW-1:0] wa;
                wa = m_addr();
                for (int g = 0; g < LN; g++)
                    if (lw[g]) m_mem[wa][g*LW +: LW] = wd[g*LW +: LW];
            end
            if (!adv) begin
                if (cs == SEL) begin
                    m_op = wn ? 1 : 2; m_base = a; m_cnt = '0;
                end else begin
                    m_op = 0;
                end
            end else if (m_op != 0) begin
                m_cnt = m_cnt + 2'd1;
            end
        end
        #1;
        check_out(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1", DW'(drive_en), '0);
        chk("R1", rdata, '0);
        rst_n = 1'b1;
        cyc("R1", 1, DSL, 1, 0, 0, '0, '0);

        // R3: fill every word, data given one cycle after each command
        for (int a = 0; a < DEPTH; a++)
            cyc("R3", 1, SEL, 0, 0, AW'(a), pat(a - 1, 0), '1);
        cyc("R3", 1, DSL, 1, 0, 0, pat(DEPTH - 1, 0), '1);

        // R2: read sweep
        for (int a = 0; a < DEPTH; a++)
            cyc("R2", 1, SEL, 1, 0, AW'(a), '0, '0);

        // R4 / R6: alternate write and read of the same word
        for (int a = 0; a < 16; a++) begin
            cyc("R6", 1, SEL, 0, 0, AW'(a), '0, '0);
            cyc("R4", 1, SEL, 1, 0, AW'(a), pat(a, 1), '1);
        end

        // R3: every lane mask
        for (int m = 0; m < 16; m++) begin
            cyc("R6", 1, SEL, 0, 0, AW'(20), '0, '0);
            cyc("R3", 1, SEL, 1, 0, AW'(20), pat(m, 2), LN'(m));
        end

        // R5: every chip-enable combination
        for (int c = 0; c < 8; c++) begin
            cyc("R5", 1, 3'(c), 0, 0, AW'(30), '0, '0);
            cyc("R5", 1, SEL, 1, 0, AW'(30), pat(c, 3), '1);
        end

        // R7: asynchronous output enable
        out_en_n = 1'b1;
        cyc("R7", 1, SEL, 1, 0, AW'(5), '0, '0);
        out_en_n = 1'b0; #1;
        chk("R7", DW'(drive_en), DW'(1));
        chk("R7", rdata, m_mem[5]);
        out_en_n = 1'b1; #1;
        chk("R7", DW'(drive_en), '0);
        out_en_n = 1'b0;

        // R8: frozen edges
        cyc("R8", 1, SEL, 1, 0, AW'(7), '0, '0);
        cyc("R8", 0, SEL, 0, 0, AW'(8), pat(99, 9), '1);
        cyc("R8", 0, DSL, 1, 0, AW'(8), pat(98, 9), '1);
        cyc("R8", 1, SEL, 0, 0, AW'(9), '0, '0);
        cyc("R8", 0, SEL, 1, 0, AW'(9), pat(97, 9), '1);
        cyc("R8", 1, DSL, 1, 0, AW'(0), pat(9, 5), '1);
        cyc("R8", 1, SEL, 1, 0, AW'(9), '0, '0);
        cyc("R8", 1, SEL, 1, 0, AW'(8), '0, '0);

        // R9 / R10: read bursts from every start offset
        for (int ilv = 0; ilv < 2; ilv++) begin
            burst_ilv = ilv[0];
            for (int s = 0; s < 4; s++) begin
                cyc(ilv ? "R10" : "R9", 1, SEL, 1, 0, AW'(40 + s), '0, '0);
                for (int n = 1; n < 4; n++) begin
                    cyc(ilv ? "R10" : "R9", 1, DSL, 0, 1, AW'(0), '0, '0);
                    chk(ilv ? "R10" : "R9", rdata,
                        m_mem[40 + (ilv ? (s ^ n) : ((s + n) % 4))]);
                end
            end
        end

        // R11: interleaved write burst, then linear read back
        burst_ilv = 1'b1;
        cyc("R11", 1, SEL, 0, 0, AW'(50), '0, '0);
        for (int n = 0; n < 3; n++)
            cyc("R11", 1, DSL, 1, 1, AW'(0), pat(n, 6), '1);
        cyc("R11", 1, DSL, 1, 0, AW'(0), pat(3, 6), '1);
        burst_ilv = 1'b0;
        cyc("R11", 1, SEL, 1, 0, AW'(48), '0, '0);
        for (int n = 1; n < 4; n++)
            cyc("R11", 1, SEL, 0, 1, AW'(1), pat(55, 7), '1);
        chk("R11", rdata, pat(2 ^ 3, 6));
        // deselect then advance stays quiet
        cyc("R11", 1, DSL, 1, 0, AW'(0), '0, '0);
        cyc("R11", 1, SEL, 0, 1, AW'(3), '0, '0);
        cyc("R11", 1, DSL, 1, 0, AW'(3), pat(77, 8), '1);
        cyc("R11", 1, SEL, 1, 0, AW'(3), '0, '0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule